// File: doc/BRIEF.md
# Trap-Return State Update Unit

This unit computes the architectural state change performed by the three trap-return instructions of a privileged processor core: the supervisor return, the machine return and the resumable non-maskable-interrupt return. On a return strobe it takes the current privilege and virtualization state, the relevant status, hypervisor-status and NMI-status bits, the three saved exception PCs and a set of feature flags. It then either commits a new privilege mode, virtualization flag, return PC, landing-pad expectation and updated status bits, or reports an exception with its cause.

Legality conditions are checked in a fixed priority order for each return kind. The first failing condition selects the cause. All field rules are applied together in one register stage. The register files themselves and the contents moved by a hypervisor register swap live elsewhere. This unit only raises a one-cycle swap request.

Top module: `trap_ret_unit`

## Requirements
- R1: Each cycle with `ret_valid_i` high produces exactly one of `commit_o` or `exc_o` in the next cycle, and neither is raised otherwise. Return kind codes are 0 = supervisor, 1 = machine, 2 = NMI, and 3 = reserved, which raises illegal-instruction. Privilege codes are U=0, S=1, M=3. Cause codes are misaligned=0, access-fault=1, illegal=2, virtual-instruction=22. Out of reset `priv_o` is 3 and both strobes are low.
- R2: A supervisor return checks its conditions in this order. First, illegal when privilege is below S. Second, misaligned (R3). Third, illegal when `trap_sret_i` is set and privilege is not M. Fourth, virtual-instruction when `virt_i` and `vtrap_sret_i` are both set.
- R3: When `has_c_i` is low, a selected return PC with either of bits [1:0] nonzero raises misaligned. This check comes right after the privilege check for every kind. When `has_c_i` is high, these bits are not checked.
- R4: A committed supervisor return sets the supervisor interrupt enable to the supervisor previous-enable bit, sets that previous-enable bit to 1, and clears the supervisor previous-privilege bit. It returns to S if that bit was 1 and to U otherwise. `mod_priv_o` is cleared only when `new_spec_i` is set.
- R5: On a supervisor return with `has_h_i` set and `virt_i` clear, the new virtualization flag comes from `sup_prev_virt_i`, `sup_prev_virt_o` is cleared, and `hyp_swap_o` is raised if that bit was set. In all other cases virtualization and `sup_prev_virt` are kept, and no swap is requested.
- R6: A machine or NMI return raises illegal unless privilege is M.
- R7: A machine or NMI return raises access-fault when `pmp_en_i` is set, `pmp_rules_i` is zero and the target privilege is not M. This check has lower priority than R3.
- R8: A committed machine return sets the machine interrupt enable to the machine previous-enable bit and sets that previous-enable bit to 1. It sets the machine previous-privilege field to U if `has_u_i` is set and to M otherwise, clears `mach_prev_virt_o`, and returns to the mode in `mach_prev_priv_i`.
- R9: For machine and NMI returns, the new virtualization flag is the saved virtualization bit AND (target != M), and `hyp_swap_o` equals `has_h_i` AND that flag. `mod_priv_o` is cleared when the target is not M. For the machine return this also requires `new_spec_i`.
- R10: A committed NMI return sets `nmi_en_o` to 1 and returns to the mode in `nmi_prev_priv_i`.
- R11: When `fcfi_en_i` is set, `lpad_exp_o` takes the saved landing-pad bit of the return kind. Otherwise it keeps `lpad_exp_i`. The saved landing-pad bit of that kind is cleared on every commit.
- R12: When an exception is raised, all state outputs equal the inputs of the strobe cycle and `hyp_swap_o` stays low.
- R13: On commit, `ret_pc_o` is `sup_epc_i`, `mach_epc_i` or `nmi_epc_i` for the supervisor, machine or NMI return respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ret_valid_i | input | 1 | Return strobe |
| ret_kind_i | input | 2 | Return kind code |
| priv_i | input | 2 | Current privilege |
| virt_i | input | 1 | Currently virtualized |
| has_c_i | input | 1 | Compressed ISA present |
| has_u_i | input | 1 | User mode present |
| has_h_i | input | 1 | Hypervisor extension present |
| new_spec_i | input | 1 | Privileged spec 1.12 or later |
| pmp_en_i | input | 1 | Physical memory protection present |
| pmp_rules_i | input | PMP_CNT_W | Number of protection rules |
| fcfi_en_i | input | 1 | Forward-CFI enabled for target mode |
| lpad_exp_i | input | 1 | Current expected-landing-pad bit |
| sup_epc_i | input | XLEN | Supervisor saved PC |
| mach_epc_i | input | XLEN | Machine saved PC |
| nmi_epc_i | input | XLEN | NMI saved PC |
| sup_int_en_i | input | 1 | Supervisor interrupt enable |
| sup_prev_int_en_i | input | 1 | Supervisor previous interrupt enable |
| sup_prev_priv_i | input | 1 | Supervisor previous privilege |
| mach_int_en_i | input | 1 | Machine interrupt enable |
| mach_prev_int_en_i | input | 1 | Machine previous interrupt enable |
| mach_prev_priv_i | input | 2 | Machine previous privilege |
| mach_prev_virt_i | input | 1 | Machine previous virtualization |
| mod_priv_i | input | 1 | Modify-privilege-for-loads/stores bit |
| trap_sret_i | input | 1 | Trap supervisor return |
| sup_prev_lpad_i | input | 1 | Supervisor saved landing-pad bit |
| mach_prev_lpad_i | input | 1 | Machine saved landing-pad bit |
| sup_prev_virt_i | input | 1 | Hypervisor saved virtualization |
| vtrap_sret_i | input | 1 | Trap supervisor return when virtualized |
| nmi_en_i | input | 1 | NMI enable |
| nmi_prev_priv_i | input | 2 | NMI previous privilege |
| nmi_prev_virt_i | input | 1 | NMI previous virtualization |
| nmi_prev_lpad_i | input | 1 | NMI saved landing-pad bit |
| commit_o | output | 1 | Return committed |
| exc_o | output | 1 | Exception raised |
| exc_cause_o | output | 5 | Exception cause |
| priv_o | output | 2 | New privilege |
| virt_o | output | 1 | New virtualization flag |
| lpad_exp_o | output | 1 | New expected-landing-pad bit |
| ret_pc_o | output | XLEN | Return PC |
| hyp_swap_o | output | 1 | Hypervisor register swap request |
| sup_int_en_o | output | 1 | Updated supervisor interrupt enable |
| sup_prev_int_en_o | output | 1 | Updated supervisor previous enable |
| sup_prev_priv_o | output | 1 | Updated supervisor previous privilege |
| mach_int_en_o | output | 1 | Updated machine interrupt enable |
| mach_prev_int_en_o | output | 1 | Updated machine previous enable |
| mach_prev_priv_o | output | 2 | Updated machine previous privilege |
| mach_prev_virt_o | output | 1 | Updated machine previous virtualization |
| mod_priv_o | output | 1 | Updated modify-privilege bit |
| sup_prev_lpad_o | output | 1 | Updated supervisor saved landing-pad bit |
| mach_prev_lpad_o | output | 1 | Updated machine saved landing-pad bit |
| sup_prev_virt_o | output | 1 | Updated hypervisor saved virtualization |
| nmi_en_o | output | 1 | Updated NMI enable |
| nmi_prev_lpad_o | output | 1 | Updated NMI saved landing-pad bit |

## Verification
Every result, whether a commit or an exception with its cause and state, is due exactly one clock edge after the strobe cycle. There is no longer path through the unit. The bench drives a strobe on a falling edge and releases it on the next falling edge. It samples all outputs at that same falling edge, half a period after the capturing rising edge. It also checks that a cycle without a strobe yields no result on the following falling edge. The table vectors cover the legality orderings. The directed tests cover the field rules, the spec-version and user-mode variants, and landing-pad restore.

// File: rtl/trap_ret_pkg.sv
package trap_ret_pkg;
  localparam logic [1:0] KIND_SRET  = 2'd0;
  localparam logic [1:0] KIND_MRET  = 2'd1;
  localparam logic [1:0] KIND_MNRET = 2'd2;

  localparam logic [1:0] PRIV_U = 2'd0;
  localparam logic [1:0] PRIV_S = 2'd1;
  localparam logic [1:0] PRIV_M = 2'd3;

  localparam int CAUSE_W = 5;
  localparam logic [CAUSE_W-1:0] CAUSE_MISALIGN = 5'd0;
  localparam logic [CAUSE_W-1:0] CAUSE_ACCESS   = 5'd1;
  localparam logic [CAUSE_W-1:0] CAUSE_ILLEGAL  = 5'd2;
  localparam logic [CAUSE_W-1:0] CAUSE_VIRT     = 5'd22;

  typedef struct packed {
    logic       sup_ie;
    logic       sup_pie;
    logic       sup_pp;
    logic       mach_ie;
    logic       mach_pie;
    logic [1:0] mach_pp;
    logic       mach_pv;
    logic       mod_priv;
    logic       sup_plp;
    logic       mach_plp;
    logic       sup_pv;
    logic       nmi_en;
    logic [1:0] nmi_pp;
    logic       nmi_pv;
    logic       nmi_plp;
  } stat_t;
endpackage

// File: rtl/trap_ret_check.sv
module trap_ret_check
  import trap_ret_pkg::*;
#(
  parameter int PMP_CNT_W = 7
) (
  input  logic [1:0]         kind_i,
  input  logic [1:0]         priv_i,
  input  logic               virt_i,
  input  logic               has_c_i,
  input  logic               pmp_en_i,
  input  logic [PMP_CNT_W-1:0] pmp_rules_i,
  input  logic               trap_sret_i,
  input  logic               vtrap_sret_i,
  input  logic [1:0]         pc_low_i,
  input  logic [1:0]         tgt_priv_i,
  output logic               exc_o,
  output logic [CAUSE_W-1:0] cause_o
);
  logic misal;
  logic no_rules;

  assign misal    = !has_c_i && (pc_low_i != 2'b00);
  assign no_rules = pmp_en_i && (pmp_rules_i == '0);

  // priority order matters: first failing condition wins
  always_comb begin
    exc_o   = 1'b0;
    cause_o = CAUSE_MISALIGN;
    unique case (kind_i)
      KIND_SRET: begin
        if (priv_i < PRIV_S) begin
          exc_o = 1'b1; cause_o = CAUSE_ILLEGAL;
        end else if (misal) begin
          exc_o = 1'b1; cause_o = CAUSE_MISALIGN;
        end else if (trap_sret_i && priv_i != PRIV_M) begin
          exc_o = 1'b1; cause_o = CAUSE_ILLEGAL;
        end else if (virt_i && vtrap_sret_i) begin
          exc_o = 1'b1; cause_o = CAUSE_VIRT;
        end
      end
      KIND_MRET, KIND_MNRET: begin
        if (priv_i != PRIV_M) begin
          exc_o = 1'b1; cause_o = CAUSE_ILLEGAL;
        end else if (misal) begin
          exc_o = 1'b1; cause_o = CAUSE_MISALIGN;
        end else if (no_rules && tgt_priv_i != PRIV_M) begin
          exc_o = 1'b1; cause_o = CAUSE_ACCESS;
        end
      end
      default: begin
        exc_o = 1'b1; cause_o = CAUSE_ILLEGAL;
      end
    endcase
  end
endmodule

// File: rtl/trap_ret_update.sv
module trap_ret_update
  import trap_ret_pkg::*;
(
  input  logic [1:0] kind_i,
  input  logic [1:0] priv_i,
  input  logic       virt_i,
  input  logic       has_u_i,
  input  logic       has_h_i,
  input  logic       new_spec_i,
  input  logic       fcfi_en_i,
  input  logic       lpad_i,
  input  stat_t      stat_i,
  output stat_t      stat_o,
  output logic [1:0] tgt_priv_o,
  output logic       virt_o,
  output logic       swap_o,
  output logic       lpad_o
);
  always_comb begin
    stat_o     = stat_i;
    tgt_priv_o = priv_i;
    virt_o     = virt_i;
    swap_o     = 1'b0;
    lpad_o     = lpad_i;
    unique case (kind_i)
      KIND_SRET: begin
        tgt_priv_o     = stat_i.sup_pp ? PRIV_S : PRIV_U;
        stat_o.sup_ie  = stat_i.sup_pie;
        stat_o.sup_pie = 1'b1;
        stat_o.sup_pp  = 1'b0;
        if (new_spec_i) stat_o.mod_priv = 1'b0;
        if (has_h_i && !virt_i) begin
          virt_o        = stat_i.sup_pv;
          stat_o.sup_pv = 1'b0;
          swap_o        = stat_i.sup_pv;
        end
        if (fcfi_en_i) lpad_o = stat_i.sup_plp;
        stat_o.sup_plp = 1'b0;
      end
      KIND_MRET: begin
        tgt_priv_o      = stat_i.mach_pp;
        virt_o          = stat_i.mach_pv && (stat_i.mach_pp != PRIV_M);
        stat_o.mach_ie  = stat_i.mach_pie;
        stat_o.mach_pie = 1'b1;
        stat_o.mach_pp  = has_u_i ? PRIV_U : PRIV_M;
        stat_o.mach_pv  = 1'b0;
        if (new_spec_i && stat_i.mach_pp != PRIV_M) stat_o.mod_priv = 1'b0;
        swap_o = has_h_i && stat_i.mach_pv && (stat_i.mach_pp != PRIV_M);
        if (fcfi_en_i) lpad_o = stat_i.mach_plp;
        stat_o.mach_plp = 1'b0;
      end
      KIND_MNRET: begin
        tgt_priv_o    = stat_i.nmi_pp;
        virt_o        = stat_i.nmi_pv && (stat_i.nmi_pp != PRIV_M);
        stat_o.nmi_en = 1'b1;
        if (stat_i.nmi_pp != PRIV_M) stat_o.mod_priv = 1'b0;
        swap_o = has_h_i && stat_i.nmi_pv && (stat_i.nmi_pp != PRIV_M);
        if (fcfi_en_i) lpad_o = stat_i.nmi_plp;
        stat_o.nmi_plp = 1'b0;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/trap_ret_unit.sv
module trap_ret_unit
  import trap_ret_pkg::*;
#(
  parameter int XLEN      = 64,
  parameter int PMP_CNT_W = 7
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 ret_valid_i,
  input  logic [1:0]           ret_kind_i,
  input  logic [1:0]           priv_i,
  input  logic                 virt_i,
  input  logic                 has_c_i,
  input  logic                 has_u_i,
  input  logic                 has_h_i,
  input  logic                 new_spec_i,
  input  logic                 pmp_en_i,
  input  logic [PMP_CNT_W-1:0] pmp_rules_i,
  input  logic                 fcfi_en_i,
  input  logic                 lpad_exp_i,
  input  logic [XLEN-1:0]      sup_epc_i,
  input  logic [XLEN-1:0]      mach_epc_i,
  input  logic [XLEN-1:0]      nmi_epc_i,
  input  logic                 sup_int_en_i,
  input  logic                 sup_prev_int_en_i,
  input  logic                 sup_prev_priv_i,
  input  logic                 mach_int_en_i,
  input  logic                 mach_prev_int_en_i,
  input  logic [1:0]           mach_prev_priv_i,
  input  logic                 mach_prev_virt_i,
  input  logic                 mod_priv_i,
  input  logic                 trap_sret_i,
  input  logic                 sup_prev_lpad_i,
  input  logic                 mach_prev_lpad_i,
  input  logic                 sup_prev_virt_i,
  input  logic                 vtrap_sret_i,
  input  logic                 nmi_en_i,
  input  logic [1:0]           nmi_prev_priv_i,
  input  logic                 nmi_prev_virt_i,
  input  logic                 nmi_prev_lpad_i,
  output logic                 commit_o,
  output logic                 exc_o,
  output logic [4:0]           exc_cause_o,
  output logic [1:0]           priv_o,
  output logic                 virt_o,
  output logic                 lpad_exp_o,
  output logic [XLEN-1:0]      ret_pc_o,
  output logic                 hyp_swap_o,
  output logic                 sup_int_en_o,
  output logic                 sup_prev_int_en_o,
  output logic                 sup_prev_priv_o,
  output logic                 mach_int_en_o,
  output logic                 mach_prev_int_en_o,
  output logic [1:0]           mach_prev_priv_o,
  output logic                 mach_prev_virt_o,
  output logic                 mod_priv_o,
  output logic                 sup_prev_lpad_o,
  output logic                 mach_prev_lpad_o,
  output logic                 sup_prev_virt_o,
  output logic                 nmi_en_o,
  output logic                 nmi_prev_lpad_o
);
  stat_t              stat_in, stat_upd, stat_q;
  logic [1:0]         tgt_priv;
  logic               upd_virt, upd_swap, upd_lpad;
  logic               chk_exc;
  logic [CAUSE_W-1:0] chk_cause;
  logic [XLEN-1:0]    sel_pc;

  assign stat_in = '{
    sup_ie:   sup_int_en_i,
    sup_pie:  sup_prev_int_en_i,
    sup_pp:   sup_prev_priv_i,
    mach_ie:  mach_int_en_i,
    mach_pie: mach_prev_int_en_i,
    mach_pp:  mach_prev_priv_i,
    mach_pv:  mach_prev_virt_i,
    mod_priv: mod_priv_i,
    sup_plp:  sup_prev_lpad_i,
    mach_plp: mach_prev_lpad_i,
    sup_pv:   sup_prev_virt_i,
    nmi_en:   nmi_en_i,
    nmi_pp:   nmi_prev_priv_i,
    nmi_pv:   nmi_prev_virt_i,
    nmi_plp:  nmi_prev_lpad_i
  };

  always_comb begin
    unique case (ret_kind_i)
      KIND_SRET:  sel_pc = sup_epc_i;
      KIND_MRET:  sel_pc = mach_epc_i;
      KIND_MNRET: sel_pc = nmi_epc_i;
      default:    sel_pc = mach_epc_i;
    endcase
  end

  trap_ret_update u_update (
    .kind_i     (ret_kind_i),
    .priv_i     (priv_i),
    .virt_i     (virt_i),
    .has_u_i    (has_u_i),
    .has_h_i    (has_h_i),
    .new_spec_i (new_spec_i),
    .fcfi_en_i  (fcfi_en_i),
    .lpad_i     (lpad_exp_i),
    .stat_i     (stat_in),
    .stat_o     (stat_upd),
    .tgt_priv_o (tgt_priv),
    .virt_o     (upd_virt),
    .swap_o     (upd_swap),
    .lpad_o     (upd_lpad)
  );

  trap_ret_check #(.PMP_CNT_W(PMP_CNT_W)) u_check (
    .kind_i       (ret_kind_i),
    .priv_i       (priv_i),
    .virt_i       (virt_i),
    .has_c_i      (has_c_i),
    .pmp_en_i     (pmp_en_i),
    .pmp_rules_i  (pmp_rules_i),
    .trap_sret_i  (trap_sret_i),
    .vtrap_sret_i (vtrap_sret_i),
    .pc_low_i     (sel_pc[1:0]),
    .tgt_priv_i   (tgt_priv),
    .exc_o        (chk_exc),
    .cause_o      (chk_cause)
  );

  // single commit point: everything lands on the edge after the strobe
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      commit_o    <= 1'b0;
      exc_o       <= 1'b0;
      exc_cause_o <= '0;
      priv_o      <= PRIV_M;
      virt_o      <= 1'b0;
      lpad_exp_o  <= 1'b0;
      ret_pc_o    <= '0;
      hyp_swap_o  <= 1'b0;
      stat_q      <= '0;
    end else begin
      commit_o   <= ret_valid_i && !chk_exc;
      exc_o      <= ret_valid_i && chk_exc;
      hyp_swap_o <= ret_valid_i && !chk_exc && upd_swap;
      if (ret_valid_i) begin
        exc_cause_o <= chk_exc ? chk_cause : '0;
        ret_pc_o    <= sel_pc;
        if (chk_exc) begin
          priv_o     <= priv_i;
          virt_o     <= virt_i;
          lpad_exp_o <= lpad_exp_i;
          stat_q     <= stat_in;
        end else begin
          priv_o     <= tgt_priv;
          virt_o     <= upd_virt;
          lpad_exp_o <= upd_lpad;
          stat_q     <= stat_upd;
        end
      end
    end
  end

  assign sup_int_en_o       = stat_q.sup_ie;
  assign sup_prev_int_en_o  = stat_q.sup_pie;
  assign sup_prev_priv_o    = stat_q.sup_pp;
  assign mach_int_en_o      = stat_q.mach_ie;
  assign mach_prev_int_en_o = stat_q.mach_pie;
  assign mach_prev_priv_o   = stat_q.mach_pp;
  assign mach_prev_virt_o   = stat_q.mach_pv;
  assign mod_priv_o         = stat_q.mod_priv;
  assign sup_prev_lpad_o    = stat_q.sup_plp;
  assign mach_prev_lpad_o   = stat_q.mach_plp;
  assign sup_prev_virt_o    = stat_q.sup_pv;
  assign nmi_en_o           = stat_q.nmi_en;
  assign nmi_prev_lpad_o    = stat_q.nmi_plp;

  a_r1_one_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ret_valid_i |=> (commit_o != exc_o));
  a_r1_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ret_valid_i |=> (!commit_o && !exc_o));
  a_r12_no_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ret_valid_i && chk_exc |=> (priv_o == $past(priv_i)) && (virt_o == $past(virt_i))
                              && !hyp_swap_o);
  a_r3_misaligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ret_valid_i && ret_kind_i == KIND_MRET && priv_i == PRIV_M && !has_c_i
      && mach_epc_i[1:0] != 2'b00 |=> exc_o && exc_cause_o == CAUSE_MISALIGN);
  a_r6_need_machine: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ret_valid_i && ret_kind_i != KIND_SRET && priv_i != PRIV_M
      |=> exc_o && exc_cause_o == CAUSE_ILLEGAL);
  a_r4_sret_fields: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ret_valid_i && ret_kind_i == KIND_SRET |=> exc_o || (sup_prev_int_en_o && !sup_prev_priv_o));
  a_r8_mret_fields: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ret_valid_i && ret_kind_i == KIND_MRET |=> exc_o || (mach_prev_int_en_o && !mach_prev_virt_o));
  a_r10_nmi_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ret_valid_i && ret_kind_i == KIND_MNRET |=> exc_o || (nmi_en_o && !nmi_prev_lpad_o));
  a_r9_swap_virt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hyp_swap_o |-> commit_o && virt_o);
endmodule

// File: tb/trap_ret_unit_tb.sv
module trap_ret_unit_tb;
  localparam int XLEN = 64;
  localparam int PW   = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic ret_valid; logic [1:0] ret_kind; logic [1:0] priv; logic virt;
  logic has_c, has_u, has_h, new_spec, pmp_en; logic [PW-1:0] pmp_rules;
  logic fcfi_en, lpad_in;
  logic [XLEN-1:0] sepc, mepc, nepc;
  logic s_ie, s_pie, s_pp, m_ie, m_pie; logic [1:0] m_pp; logic m_pv, mprv, tsr;
  logic s_plp, m_plp, s_pv, vtsr, n_en; logic [1:0] n_pp; logic n_pv, n_plp;

  logic commit, exc; logic [4:0] cause; logic [1:0] priv_q; logic virt_q, lpad_q;
  logic [XLEN-1:0] ret_pc; logic swap;
  logic s_ie_q, s_pie_q, s_pp_q, m_ie_q, m_pie_q; logic [1:0] m_pp_q;
  logic m_pv_q, mprv_q, s_plp_q, m_plp_q, s_pv_q, n_en_q, n_plp_q;

  trap_ret_unit #(.XLEN(XLEN), .PMP_CNT_W(PW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .ret_valid_i(ret_valid), .ret_kind_i(ret_kind),
    .priv_i(priv), .virt_i(virt), .has_c_i(has_c), .has_u_i(has_u), .has_h_i(has_h),
    .new_spec_i(new_spec), .pmp_en_i(pmp_en), .pmp_rules_i(pmp_rules), .fcfi_en_i(fcfi_en),
    .lpad_exp_i(lpad_in), .sup_epc_i(sepc), .mach_epc_i(mepc), .nmi_epc_i(nepc),
    .sup_int_en_i(s_ie), .sup_prev_int_en_i(s_pie), .sup_prev_priv_i(s_pp),
    .mach_int_en_i(m_ie), .mach_prev_int_en_i(m_pie), .mach_prev_priv_i(m_pp),
    .mach_prev_virt_i(m_pv), .mod_priv_i(mprv), .trap_sret_i(tsr),
    .sup_prev_lpad_i(s_plp), .mach_prev_lpad_i(m_plp), .sup_prev_virt_i(s_pv),
    .vtrap_sret_i(vtsr), .nmi_en_i(n_en), .nmi_prev_priv_i(n_pp), .nmi_prev_virt_i(n_pv),
    .nmi_prev_lpad_i(n_plp),
    .commit_o(commit), .exc_o(exc), .exc_cause_o(cause), .priv_o(priv_q), .virt_o(virt_q),
    .lpad_exp_o(lpad_q), .ret_pc_o(ret_pc), .hyp_swap_o(swap),
    .sup_int_en_o(s_ie_q), .sup_prev_int_en_o(s_pie_q), .sup_prev_priv_o(s_pp_q),
    .mach_int_en_o(m_ie_q), .mach_prev_int_en_o(m_pie_q), .mach_prev_priv_o(m_pp_q),
    .mach_prev_virt_o(m_pv_q), .mod_priv_o(mprv_q), .sup_prev_lpad_o(s_plp_q),
    .mach_prev_lpad_o(m_plp_q), .sup_prev_virt_o(s_pv_q), .nmi_en_o(n_en_q),
    .nmi_prev_lpad_o(n_plp_q)
  );

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic defaults();
    ret_valid = 0; ret_kind = 2'd1; priv = 2'd3; virt = 0;
    has_c = 1; has_u = 1; has_h = 1; new_spec = 1; pmp_en = 0; pmp_rules = 7'd4;
    fcfi_en = 0; lpad_in = 0;
    sepc = 64'h1000; mepc = 64'h2000; nepc = 64'h3000;
    s_ie = 0; s_pie = 0; s_pp = 0; m_ie = 0; m_pie = 0; m_pp = 0; m_pv = 0; mprv = 0; tsr = 0;
    s_plp = 0; m_plp = 0; s_pv = 0; vtsr = 0; n_en = 0; n_pp = 0; n_pv = 0; n_plp = 0;
  endtask

  // strobe for one cycle; result sampled at the falling edge after capture
  task automatic fire();
    ret_valid = 1;
    @(negedge clk);
    ret_valid = 0;
  endtask

  typedef struct packed {
    logic [1:0] kind; logic [1:0] pv; logic vt; logic c; logic [1:0] pcl;
    logic ts; logic vts; logic [1:0] tgt; logic sv; logic pmp0;
    logic x; logic [4:0] cs; logic [1:0] ep; logic ev; logic esw;
  } vec_t;

  // kind pv vt c pcl ts vts tgt sv pmp0 | x cause priv virt swap
  localparam vec_t VECS [21] = '{
    '{2'd0,2'd1,1'b0,1'b1,2'd0,1'b0,1'b0,2'd0,1'b0,1'b0, 1'b0,5'd0, 2'd0,1'b0,1'b0}, // R4 S->U
    '{2'd0,2'd0,1'b0,1'b1,2'd0,1'b0,1'b0,2'd0,1'b0,1'b0, 1'b1,5'd2, 2'd0,1'b0,1'b0}, // R2 from U
    '{2'd0,2'd1,1'b0,1'b1,2'd0,1'b1,1'b0,2'd0,1'b0,1'b0, 1'b1,5'd2, 2'd1,1'b0,1'b0}, // R2 tsr in S
    '{2'd0,2'd3,1'b0,1'b1,2'd0,1'b1,1'b0,2'd1,1'b0,1'b0, 1'b0,5'd0, 2'd1,1'b0,1'b0}, // R2 tsr ok in M
    '{2'd0,2'd1,1'b1,1'b1,2'd0,1'b0,1'b1,2'd0,1'b0,1'b0, 1'b1,5'd22,2'd1,1'b1,1'b0}, // R2 vtsr
    '{2'd0,2'd1,1'b1,1'b1,2'd0,1'b1,1'b1,2'd0,1'b0,1'b0, 1'b1,5'd2, 2'd1,1'b1,1'b0}, // R2 tsr beats vtsr
    '{2'd0,2'd1,1'b0,1'b1,2'd0,1'b0,1'b0,2'd1,1'b1,1'b0, 1'b0,5'd0, 2'd1,1'b1,1'b1}, // R5 spv swap
    '{2'd0,2'd1,1'b1,1'b1,2'd0,1'b0,1'b0,2'd0,1'b1,1'b0, 1'b0,5'd0, 2'd0,1'b1,1'b0}, // R5 virt kept
    '{2'd0,2'd1,1'b0,1'b0,2'd2,1'b0,1'b0,2'd0,1'b0,1'b0, 1'b1,5'd0, 2'd1,1'b0,1'b0}, // R3 sret
    '{2'd0,2'd0,1'b0,1'b0,2'd2,1'b0,1'b0,2'd0,1'b0,1'b0, 1'b1,5'd2, 2'd0,1'b0,1'b0}, // R2 priv first
    '{2'd1,2'd1,1'b0,1'b1,2'd0,1'b0,1'b0,2'd0,1'b0,1'b0, 1'b1,5'd2, 2'd1,1'b0,1'b0}, // R6 mret in S
    '{2'd1,2'd3,1'b0,1'b1,2'd0,1'b0,1'b0,2'd1,1'b1,1'b0, 1'b0,5'd0, 2'd1,1'b1,1'b1}, // R9 mret to VS
    '{2'd1,2'd3,1'b0,1'b1,2'd0,1'b0,1'b0,2'd3,1'b1,1'b0, 1'b0,5'd0, 2'd3,1'b0,1'b0}, // R9 target M
    '{2'd1,2'd3,1'b0,1'b1,2'd0,1'b0,1'b0,2'd0,1'b0,1'b1, 1'b1,5'd1, 2'd3,1'b0,1'b0}, // R7 no rules
    '{2'd1,2'd3,1'b0,1'b1,2'd0,1'b0,1'b0,2'd3,1'b0,1'b1, 1'b0,5'd0, 2'd3,1'b0,1'b0}, // R7 to M ok
    '{2'd1,2'd3,1'b0,1'b0,2'd1,1'b0,1'b0,2'd0,1'b0,1'b1, 1'b1,5'd0, 2'd3,1'b0,1'b0}, // R3 before R7
    '{2'd2,2'd0,1'b0,1'b1,2'd0,1'b0,1'b0,2'd0,1'b0,1'b0, 1'b1,5'd2, 2'd0,1'b0,1'b0}, // R6 nmi in U
    '{2'd2,2'd3,1'b0,1'b1,2'd0,1'b0,1'b0,2'd0,1'b1,1'b0, 1'b0,5'd0, 2'd0,1'b1,1'b1}, // R10 nmi to U
    '{2'd2,2'd3,1'b0,1'b1,2'd0,1'b0,1'b0,2'd1,1'b0,1'b1, 1'b1,5'd1, 2'd3,1'b0,1'b0}, // R7 nmi
    '{2'd1,2'd3,1'b0,1'b1,2'd2,1'b0,1'b0,2'd0,1'b0,1'b0, 1'b0,5'd0, 2'd0,1'b0,1'b0}, // R3 with C
    '{2'd3,2'd3,1'b0,1'b1,2'd0,1'b0,1'b0,2'd0,1'b0,1'b0, 1'b1,5'd2, 2'd3,1'b0,1'b0}  // R1 reserved
  };

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    defaults();
    repeat (3) @(negedge clk);
    check("R1 reset commit", commit, 0);
    check("R1 reset exc", exc, 0);
    check("R1 reset priv", priv_q, 3);
    rst_n = 1;
    @(negedge clk);

    foreach (VECS[i]) begin
      vec_t v;
      string tag;
      logic [63:0] exp_pc;
      v = VECS[i];
      defaults();
      ret_kind = v.kind; priv = v.pv; virt = v.vt; has_c = v.c;
      tsr = v.ts; vtsr = v.vts; s_pp = v.tgt[0]; m_pp = v.tgt; n_pp = v.tgt;
      s_pv = v.sv; m_pv = v.sv; n_pv = v.sv;
      sepc = 64'h1000 | 64'(v.pcl); mepc = 64'h2000 | 64'(v.pcl); nepc = 64'h3000 | 64'(v.pcl);
      if (v.pmp0) begin pmp_en = 1; pmp_rules = '0; end
      exp_pc = (v.kind == 2'd0) ? sepc : (v.kind == 2'd2) ? nepc : mepc;
      tag = $sformatf("vec%0d", i);
      fire();
      check({tag, " R1 commit"}, commit, !v.x);
      check({tag, " R1 exc"}, exc, v.x);
      if (v.x) check({tag, " R2 cause"}, cause, v.cs);
      check({tag, " R9 priv"}, priv_q, v.ep);
      check({tag, " R9 virt"}, virt_q, v.ev);
      check({tag, " R5 swap"}, swap, v.esw);
      if (!v.x) check({tag, " R13 pc"}, ret_pc, exp_pc);
    end

    // R1 idle cycle gives no result
    defaults();
    @(negedge clk);
    check("R1 idle commit", commit, 0);
    check("R1 idle exc", exc, 0);

    // R4 supervisor fields, spec variants
    defaults(); ret_kind = 0; priv = 1; s_ie = 1; s_pie = 0; s_pp = 1; mprv = 1;
    fire();
    check("R4 sie", s_ie_q, 0); check("R4 spie", s_pie_q, 1);
    check("R4 spp", s_pp_q, 0); check("R4 mprv cleared", mprv_q, 0);
    check("R4 target S", priv_q, 1);
    defaults(); ret_kind = 0; priv = 1; mprv = 1; new_spec = 0; s_pie = 1;
    fire();
    check("R4 mprv kept old spec", mprv_q, 1); check("R4 sie from spie", s_ie_q, 1);

    // R5 without hypervisor: virt and spv untouched
    defaults(); ret_kind = 0; priv = 1; has_h = 0; s_pv = 1;
    fire();
    check("R5 no-h virt", virt_q, 0); check("R5 no-h spv", s_pv_q, 1); check("R5 no-h swap", swap, 0);
    defaults(); ret_kind = 0; priv = 1; s_pv = 1;
    fire();
    check("R5 spv cleared", s_pv_q, 0);

    // R8 machine fields
    defaults(); m_ie = 1; m_pie = 0; m_pp = 0; m_pv = 0; mprv = 1;
    fire();
    check("R8 mie", m_ie_q, 0); check("R8 mpie", m_pie_q, 1); check("R8 mpp user", m_pp_q, 0);
    check("R9 mprv cleared", mprv_q, 0);
    defaults(); has_u = 0; m_pp = 3; m_pv = 1; mprv = 1; m_pie = 1;
    fire();
    check("R8 mpp machine", m_pp_q, 3); check("R8 mpv cleared", m_pv_q, 0);
    check("R9 mprv kept to M", mprv_q, 1); check("R8 mie", m_ie_q, 1);
    defaults(); m_pp = 1; mprv = 1; new_spec = 0;
    fire();
    check("R9 mret mprv kept old spec", mprv_q, 1);

    // R10 NMI return
    defaults(); ret_kind = 2; n_en = 0; n_pp = 1; mprv = 1; new_spec = 0;
    fire();
    check("R10 nmie", n_en_q, 1); check("R10 target", priv_q, 1); check("R9 nmi mprv", mprv_q, 0);
    check("R13 nmi pc", ret_pc, 64'h3000);
    defaults(); ret_kind = 2; n_pp = 3; mprv = 1;
    fire();
    check("R9 nmi mprv to M", mprv_q, 1);

    // R11 landing pad
    defaults(); ret_kind = 0; priv = 1; fcfi_en = 1; s_plp = 1;
    fire();
    check("R11 sret elp", lpad_q, 1); check("R11 spelp cleared", s_plp_q, 0);
    defaults(); m_plp = 1; lpad_in = 0;
    fire();
    check("R11 no cfi elp", lpad_q, 0); check("R11 mpelp cleared", m_plp_q, 0);
    defaults(); ret_kind = 2; fcfi_en = 1; n_plp = 1;
    fire();
    check("R11 nmi elp", lpad_q, 1); check("R11 mnpelp cleared", n_plp_q, 0);

    // R12 exception leaves state
    defaults(); priv = 1; m_ie = 1; m_pie = 0; m_pp = 1; mprv = 1; m_pv = 1; lpad_in = 1; fcfi_en = 1;
    fire();
    check("R12 exc", exc, 1); check("R12 mie", m_ie_q, 1); check("R12 mpie", m_pie_q, 0);
    check("R12 mpp", m_pp_q, 1); check("R12 mprv", mprv_q, 1); check("R12 mpv", m_pv_q, 1);
    check("R12 elp", lpad_q, 1); check("R12 swap", swap, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule